// File: doc/BRIEF.md
# Self-Timed Tile Iteration Scheduler

This block decides when a compute cluster in a dataflow pipeline may start its next tile iteration. Three asynchronous resources report completion with single-cycle event pulses: the inbound DMA channel (fetching the next tile from upstream clusters), the outbound DMA channel (sending the previous result downstream) and the accelerator. Each pulse is held in a sticky flag. An iteration may start only when all three flags are set and three other conditions are true in the same cycle: the upstream cluster offers the next tile, the downstream cluster can take the previous output, and the cores report idle.

When every condition holds, the block sends a one-cycle wake event to the master core. The master then issues a single configure-and-go write. In response, the block pulses the three trigger outputs together, clears the flags, advances the tile index and then sends a one-cycle sleep event to the cores. A run is armed with a tile count. When that many launches have been made, the block reports finished and issues nothing more until a new run is started. At run start the three flags are preset, because no transfer or computation is outstanding yet.

Top module: `iter_sched`

## Requirements
- R1: While reset is held and right after it is released, `wake_ev_o`, all three trigger outputs, `sleep_ev_o` and `done_o` are low, and `tile_idx_o` is 0.
- R2: `wake_ev_o` goes high for exactly one cycle. It does so one cycle after a cycle in which the scheduler was waiting, all three completion flags were set, and `src_valid_i`, `dst_ready_i` and `cores_idle_i` were all high. It never goes high at any other time.
- R3: A completion event pulse is remembered until the next launch. The order in which the three sources report, and the spacing between their reports, do not affect when the wake is issued.
- R4: A `cfg_go_i` pulse seen after a wake and before the next launch makes `trig_in_o`, `trig_out_o` and `trig_acc_o` go high together for one cycle, one cycle later. A `cfg_go_i` pulse at any other time produces no trigger.
- R5: `sleep_ev_o` goes high for one cycle, in the cycle right after the triggers.
- R6: `tile_idx_o` increases by exactly one per launch. The new value is visible from the sleep cycle onward. A run start resets it to 0.
- R7: After the number of launches given by `cfg_tiles_i` at run start, `done_o` rises one cycle after the last sleep event and stays high. No further wake or trigger occurs until a new run start. A count of 0 gives `done_o` one cycle after the start.
- R8: `run_start_i` presets all three completion flags, so the first launch waits only for the handshakes and idle cores. A `run_start_i` pulse while a run is in progress is ignored.
- R9: A completion event that arrives in the same cycle as the triggers is kept, not lost to the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_start_i | input | 1 | Start a run; accepted only when idle or finished |
| cfg_tiles_i | input | CNT_W | Number of tiles in the run, sampled with `run_start_i` |
| in_done_ev_i | input | 1 | Inbound DMA completion pulse |
| out_done_ev_i | input | 1 | Outbound DMA completion pulse |
| acc_done_ev_i | input | 1 | Accelerator completion pulse |
| src_valid_i | input | 1 | Upstream cluster offers the next tile |
| dst_ready_i | input | 1 | Downstream cluster can accept the previous output |
| cores_idle_i | input | 1 | All cores are idle |
| cfg_go_i | input | 1 | Master core configure-and-go write |
| wake_ev_o | output | 1 | Wake event to the master core |
| trig_in_o | output | 1 | Trigger for the inbound DMA channel |
| trig_out_o | output | 1 | Trigger for the outbound DMA channel |
| trig_acc_o | output | 1 | Trigger for the accelerator |
| sleep_ev_o | output | 1 | Sleep event to the cores |
| done_o | output | 1 | Run finished |
| tile_idx_o | output | CNT_W | Number of launches made in the current run |

## Verification
Every result arrives a fixed number of cycles after its cause:
- The wake comes one cycle after the cycle in which all conditions held.
- The triggers come one cycle after an accepted go.
- The sleep event and the new tile index come one cycle after the triggers.
- `done_o` comes one cycle after the final sleep.

The reference model advances on each rising edge from the inputs held at that edge. All outputs are compared against it at the following falling edge, so every comparison lands in the cycle the output is due. The environment delivers completion events in random order and with random delays, including delays that land in the trigger cycle. It also injects stray go writes and stray events. The model therefore flags any wake or trigger that comes early or late.

// File: rtl/iter_sched_pkg.sv
package iter_sched_pkg;
    localparam int NUM_SRC = 3;
    localparam int SRC_IN  = 0;
    localparam int SRC_OUT = 1;
    localparam int SRC_ACC = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAIT,
        PH_WAKE,
        PH_ARMED,
        PH_FIRE,
        PH_SLEEP,
        PH_DONE
    } phase_e;
endpackage

// File: rtl/ev_flags.sv
module ev_flags #(
    parameter int N = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] ev_i,
    input  logic         set_all_i,
    input  logic         clr_all_i,
    output logic [N-1:0] flags_o
);
    typedef struct packed {
        logic [N-1:0] flags;
    } flg_s;

    flg_s         s_d, s_q;
    logic [N-1:0] nxt;

    // a new event wins over the clear in the same cycle
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign nxt[g] = set_all_i | ev_i[g] | (s_q.flags[g] & ~clr_all_i);
    end

    always_comb begin
        s_d       = s_q;
        s_d.flags = nxt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign flags_o = s_q.flags;
endmodule

// File: rtl/tile_ctr.sv
module tile_ctr #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] total_i,
    input  logic         inc_i,
    output logic [W-1:0] idx_o,
    output logic         reached_o
);
    typedef struct packed {
        logic [W-1:0] idx;
        logic [W-1:0] total;
    } ctr_s;

    ctr_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.idx   = '0;
            s_d.total = total_i;
        end else if (inc_i) begin
            s_d.idx = s_q.idx + W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign idx_o     = s_q.idx;
    assign reached_o = (s_q.idx == s_q.total);
endmodule

// File: rtl/iter_fsm.sv
module iter_fsm
    import iter_sched_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic zero_total_i,
    input  logic ready_i,
    input  logic go_i,
    input  logic reached_i,
    output logic load_o,
    output logic clr_o,
    output logic wake_o,
    output logic fire_o,
    output logic sleep_o,
    output logic done_o
);
    typedef struct packed {
        phase_e phase;
    } fsm_s;

    fsm_s s_d, s_q;
    logic accept;

    assign accept = start_i && (s_q.phase == PH_IDLE || s_q.phase == PH_DONE);

    always_comb begin
        s_d = s_q;
        if (accept) begin
            s_d.phase = zero_total_i ? PH_DONE : PH_WAIT;
        end else begin
            unique case (s_q.phase)
                PH_WAIT:  if (ready_i) s_d.phase = PH_WAKE;
                PH_WAKE:  s_d.phase = PH_ARMED;
                PH_ARMED: if (go_i) s_d.phase = PH_FIRE;
                PH_FIRE:  s_d.phase = PH_SLEEP;
                PH_SLEEP: s_d.phase = reached_i ? PH_DONE : PH_WAIT;
                default:  s_d.phase = s_q.phase;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{phase: PH_IDLE};
        else         s_q <= s_d;
    end

    assign load_o  = accept;
    assign clr_o   = (s_q.phase == PH_FIRE);
    assign wake_o  = (s_q.phase == PH_WAKE);
    assign fire_o  = (s_q.phase == PH_FIRE);
    assign sleep_o = (s_q.phase == PH_SLEEP);
    assign done_o  = (s_q.phase == PH_DONE);
endmodule

// File: rtl/iter_sched.sv
module iter_sched
    import iter_sched_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_start_i,
    input  logic [CNT_W-1:0] cfg_tiles_i,
    input  logic             in_done_ev_i,
    input  logic             out_done_ev_i,
    input  logic             acc_done_ev_i,
    input  logic             src_valid_i,
    input  logic             dst_ready_i,
    input  logic             cores_idle_i,
    input  logic             cfg_go_i,
    output logic             wake_ev_o,
    output logic             trig_in_o,
    output logic             trig_out_o,
    output logic             trig_acc_o,
    output logic             sleep_ev_o,
    output logic             done_o,
    output logic [CNT_W-1:0] tile_idx_o
);
    logic [NUM_SRC-1:0] ev_w;
    logic [NUM_SRC-1:0] flags_w;
    logic               load_w, clr_w, fire_w, reached_w, ready_w;

    assign ev_w[SRC_IN]  = in_done_ev_i;
    assign ev_w[SRC_OUT] = out_done_ev_i;
    assign ev_w[SRC_ACC] = acc_done_ev_i;

    assign ready_w = (&flags_w) && src_valid_i && dst_ready_i && cores_idle_i;

    ev_flags #(.N(NUM_SRC)) u_flags (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ev_i      (ev_w),
        .set_all_i (load_w),
        .clr_all_i (clr_w),
        .flags_o   (flags_w)
    );

    tile_ctr #(.W(CNT_W)) u_ctr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (load_w),
        .total_i   (cfg_tiles_i),
        .inc_i     (fire_w),
        .idx_o     (tile_idx_o),
        .reached_o (reached_w)
    );

    iter_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (run_start_i),
        .zero_total_i (cfg_tiles_i == '0),
        .ready_i      (ready_w),
        .go_i         (cfg_go_i),
        .reached_i    (reached_w),
        .load_o       (load_w),
        .clr_o        (clr_w),
        .wake_o       (wake_ev_o),
        .fire_o       (fire_w),
        .sleep_o      (sleep_ev_o),
        .done_o       (done_o)
    );

    assign trig_in_o  = fire_w;
    assign trig_out_o = fire_w;
    assign trig_acc_o = fire_w;
endmodule

// File: rtl/iter_sched_chk.sv
module iter_sched_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             run_start_i,
    input logic             acc_done_ev_i,
    input logic             src_valid_i,
    input logic             dst_ready_i,
    input logic             cores_idle_i,
    input logic             cfg_go_i,
    input logic             wake_ev_o,
    input logic             trig_acc_o,
    input logic             sleep_ev_o,
    input logic             done_o,
    input logic [CNT_W-1:0] tile_idx_o,
    input logic [2:0]       flags_i
);
    AST_WAKE_NEEDS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_ev_o |-> $past((&flags_i) && src_valid_i && dst_ready_i && cores_idle_i)); // R2
    AST_WAKE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_ev_o |=> !wake_ev_o); // R2
    AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trig_acc_o |=> ((flags_i & $past(flags_i)) == $past(flags_i))); // R3
    AST_TRIG_NEEDS_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_acc_o |-> $past(cfg_go_i)); // R4
    AST_SLEEP_AFTER_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_acc_o |=> sleep_ev_o); // R5
    AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sleep_ev_o |-> (tile_idx_o == $past(tile_idx_o) + CNT_W'(1))); // R6
    AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !run_start_i) |=> done_o); // R7
    AST_FIRE_EVENT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trig_acc_o && acc_done_ev_i) |=> flags_i[2]); // R9
endmodule

bind iter_sched iter_sched_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_start_i   (run_start_i),
    .acc_done_ev_i (acc_done_ev_i),
    .src_valid_i   (src_valid_i),
    .dst_ready_i   (dst_ready_i),
    .cores_idle_i  (cores_idle_i),
    .cfg_go_i      (cfg_go_i),
    .wake_ev_o     (wake_ev_o),
    .trig_acc_o    (trig_acc_o),
    .sleep_ev_o    (sleep_ev_o),
    .done_o        (done_o),
    .tile_idx_o    (tile_idx_o),
    .flags_i       (flags_w)
);

// File: tb/iter_sched_tb_top.sv
module iter_sched_tb_top;
    localparam int CW = 16;
    localparam int P_IDLE = 0, P_WAIT = 1, P_WAKE = 2, P_ARMED = 3,
                   P_FIRE = 4, P_SLEEP = 5, P_DONE = 6;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          run_start = 0;
    logic [CW-1:0] cfg_tiles = '0;
    logic          in_ev = 0, out_ev = 0, acc_ev = 0;
    logic          src_valid = 0, dst_ready = 0, cores_idle = 0, cfg_go = 0;
    logic          wake, t_in, t_out, t_acc, sleep_ev, done;
    logic [CW-1:0] idx;

    int  checks = 0, fails = 0;
    bit  env_on = 0;
    int  m_ph = P_IDLE, m_cnt = 0, m_tot = 0;
    bit  [2:0] m_flags = 3'b000;
    int  dly [3] = '{-1, -1, -1};
    int  go_dly = 0;

    always #5 clk = ~clk;

    iter_sched #(.CNT_W(CW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .run_start_i(run_start), .cfg_tiles_i(cfg_tiles),
        .in_done_ev_i(in_ev), .out_done_ev_i(out_ev), .acc_done_ev_i(acc_ev),
        .src_valid_i(src_valid), .dst_ready_i(dst_ready), .cores_idle_i(cores_idle),
        .cfg_go_i(cfg_go), .wake_ev_o(wake), .trig_in_o(t_in), .trig_out_o(t_out),
        .trig_acc_o(t_acc), .sleep_ev_o(sleep_ev), .done_o(done), .tile_idx_o(idx)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // behavioural reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = P_IDLE; m_flags = 0; m_cnt = 0; m_tot = 0;
        end else begin
            bit accepted;
            int nph;
            accepted = run_start && (m_ph == P_IDLE || m_ph == P_DONE);
            nph = m_ph;
            if (accepted) nph = (cfg_tiles == 0) ? P_DONE : P_WAIT;
            else if (m_ph == P_WAIT && m_flags == 3'b111 && src_valid && dst_ready && cores_idle)
                nph = P_WAKE;
            else if (m_ph == P_WAKE) nph = P_ARMED;
            else if (m_ph == P_ARMED && cfg_go) nph = P_FIRE;
            else if (m_ph == P_FIRE) nph = P_SLEEP;
            else if (m_ph == P_SLEEP) nph = (m_cnt == m_tot) ? P_DONE : P_WAIT;
            if (accepted) m_flags = 3'b111;
            else m_flags = ((m_ph == P_FIRE) ? 3'b000 : m_flags) | {acc_ev, out_ev, in_ev};
            if (accepted) begin m_cnt = 0; m_tot = int'(cfg_tiles); end
            else if (m_ph == P_FIRE) m_cnt = m_cnt + 1;
            m_ph = nph;
        end
    end

    // compare at the falling edge, then drive the environment
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2,R3,R8 wake", int'(wake), int'(m_ph == P_WAKE));
            check("R4,R9 trig_in", int'(t_in), int'(m_ph == P_FIRE));
            check("R4 trig_out", int'(t_out), int'(m_ph == P_FIRE));
            check("R4 trig_acc", int'(t_acc), int'(m_ph == P_FIRE));
            check("R5 sleep", int'(sleep_ev), int'(m_ph == P_SLEEP));
            check("R7 done", int'(done), int'(m_ph == P_DONE));
            check("R6 tile_idx", int'(idx), m_cnt);
        end
        if (env_on) begin
            bit [2:0] ev;
            src_valid  = ($urandom % 4) != 0;
            dst_ready  = ($urandom % 4) != 0;
            cores_idle = ($urandom % 3) != 0;
            for (int i = 0; i < 3; i++) begin
                ev[i] = 1'b0;
                if (dly[i] == 0) begin ev[i] = 1'b1; dly[i] = -1; end
                else if (dly[i] > 0) dly[i]--;
                if (($urandom % 40) == 0) ev[i] = 1'b1;
                if (t_acc) begin
                    int d;
                    d = $urandom_range(0, 10);
                    if (d == 0) ev[i] = 1'b1;   // lands in the trigger cycle (R9)
                    else dly[i] = d - 1;
                end
            end
            in_ev = ev[0]; out_ev = ev[1]; acc_ev = ev[2];
            cfg_go = 1'b0;
            if (go_dly > 0) begin
                go_dly--;
                if (go_dly == 0) cfg_go = 1'b1;
            end
            if (wake) go_dly = $urandom_range(1, 3);
            if (($urandom % 16) == 0) cfg_go = 1'b1;  // stray go, ignored unless armed (R4)
        end
    end

    task automatic start_run(int n);
        @(negedge clk);
        run_start = 1'b1;
        cfg_tiles = CW'(n);
        @(negedge clk);
        run_start = 1'b0;
    endtask

    task automatic wait_done(string req);
        int k;
        k = 0;
        while (!done && k < 3000) begin
            @(negedge clk);
            k++;
        end
        checks++;
        if (!done) begin
            fails++;
            $display("FAIL %s: actual done=0 expected done=1", req);
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL R7 watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check("R1 reset wake", int'(wake), 0);
        check("R1 reset trig", int'(t_in | t_out | t_acc), 0);
        check("R1 reset sleep", int'(sleep_ev), 0);
        check("R1 reset done", int'(done), 0);
        check("R1 reset idx", int'(idx), 0);
        rst_n = 1'b1;
        env_on = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 idle after reset", int'(done | wake | t_acc), 0);

        start_run(4);
        wait_done("R7 run of 4");
        check("R6 final index of 4", int'(idx), 4);

        start_run(0);
        check("R7 zero-length run", int'(done), 1);

        start_run(7);
        while (idx < 2) @(negedge clk);
        start_run(2);                       // ignored mid-run (R8)
        wait_done("R8 run of 7 after ignored start");
        check("R8 final index of 7", int'(idx), 7);

        repeat (10) @(negedge clk);
        check("R7 done held", int'(done), 1);

        for (int r = 0; r < 4; r++) begin
            int n;
            n = $urandom_range(1, 6);
            start_run(n);
            wait_done("R3 random run");
            check("R6 random final index", int'(idx), n);
        end
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule